// File: doc/BRIEF.md
# Serial Byte Transmitter with Break and Idle-Line Generation

This block sends bytes on an asynchronous serial line with fixed framing: one low start bit, eight data bits least significant first, and one high stop bit. Bytes enter through a valid/ready stream port into a one-entry holding register, which feeds an output shift register. A single-cycle bit tick supplied from outside sets the bit period. The block has no baud generator of its own.

Two plain control levels add line conditions that are not data. Each rising edge of the transmit enable queues an idle-line preamble, which is ten bit periods of high line. A rising edge of the break request queues one break word, which is ten bit periods low followed by one high bit. Holding the break request high sends break words back to back. A frame already on the line always finishes before any queued item starts. One interrupt output combines two enabled sources: holding register empty and transmission complete.

Back-pressure works like this. `in_ready` is high exactly when the holding register is empty. A byte is taken on any clock where `in_valid` and `in_ready` are both high. The producer keeps `in_data` stable while `in_valid` is high and `in_ready` is low. Bytes are accepted even while the transmitter is disabled.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, `txd` is 1, `in_ready` is 1 and `irq` is 0. The transmission-complete flag resets to 1.
- R2: A byte is accepted when `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until that byte moves into the shift register, and it rises in the cycle after that move.
- R3: A data frame is bit 0 = 0 (start), then `in_data` bits 0 to 7 in that order, then a 1 (stop). `txd` changes only in the cycle after a `bit_tick`, and each bit lasts exactly one tick period. If the holding register is full when a frame ends, the next frame starts at that same tick with no gap.
- R4: With `ie_empty` = 1, `irq` is 1 whenever the holding register is empty. The empty state persists until a byte is accepted.
- R5: The transmission-complete flag clears when a byte is accepted. It sets when a frame ends on a tick, the holding register is empty and no other frame starts. With `ie_done` = 1 the flag drives `irq`.
- R6: Each 0-to-1 transition of `tx_en` queues one idle preamble of ten high bit periods. This includes a brief low pulse in the middle of a frame. The frame in progress completes first.
- R7: A 0-to-1 transition of `brk_req` queues one break word: ten low bit periods, then one high bit period. If `brk_req` returns to 0 before that word starts or while it runs, exactly one break word is sent.
- R8: While `brk_req` stays 1 and `tx_en` is 1, break words follow each other with no gap. Each low run is exactly ten bit periods.
- R9: While `tx_en` is 0 no new frame starts and `txd` is 1 once any current frame ends. Bytes are still accepted into the holding register.
- R10: A frame never starts on the first `bit_tick` at or after a rising edge of `tx_en`. The earliest start is the second such tick.
- R11: When several items are ready at a start opportunity, the order is break word, then idle preamble, then data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| tx_en | input | 1 | Transmit enable level; its rising edge queues a preamble |
| brk_req | input | 1 | Break request level; its rising edge queues a break word |
| ie_empty | input | 1 | Interrupt enable for holding register empty |
| ie_done | input | 1 | Interrupt enable for transmission complete |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Holding register empty; byte accepted when valid and ready |
| txd | output | 1 | Serial line output, idles high |
| irq | output | 1 | Combined enabled interrupt |

## Verification
Some rules are checked by the assertions on every cycle:
- the line holds steady between ticks;
- an accepted byte drops `in_ready`, and an empty register stays empty without a write;
- a write clears the complete flag;
- nothing starts while disabled or on the tick that coincides with an enable edge.

Other behaviour depends on the order of events over many bit periods, so only the bench scenarios show it. This covers:
- the exact bit order of frames;
- a preamble after a mid-frame enable pulse;
- a single break word from a short request versus a continuous stream from a held one;
- the priority of break over preamble over data.

// File: rtl/uart_tx_brk_pkg.sv
package uart_tx_brk_pkg;
  typedef enum logic [1:0] {
    FK_DATA  = 2'd0,
    FK_IDLE  = 2'd1,
    FK_BREAK = 2'd2
  } frame_kind_e;
endpackage

// File: rtl/utx_hold.sv
module utx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);
  // wr only when empty, take only when full: never both in one cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (take) full <= 1'b0;
      if (wr) begin
        full <= 1'b1;
        data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/utx_seq.sv
module utx_seq
  import uart_tx_brk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        tx_en,
  input  logic        brk_req,
  input  logic        hold_full,
  input  logic        acc,
  input  logic        busy,
  input  logic        last,
  output logic        start,
  output frame_kind_e kind,
  output logic        take,
  output logic        tc
);
  localparam int ARM_W = 2;
  localparam logic [ARM_W-1:0] ARM_LOAD = ARM_W'(2);

  logic en_q, brk_q, brk_pend, pre_pend;
  logic [ARM_W-1:0] arm;
  logic en_rise, brk_rise, slot, go;

  assign en_rise  = tx_en & ~en_q;
  assign brk_rise = brk_req & ~brk_q;
  assign slot     = tick & (~busy | last);
  // arm at 2 means the first tick after enable has not yet passed
  assign go       = slot & tx_en & (arm < ARM_LOAD) & ~en_rise;

  always_comb begin
    start = 1'b0;
    kind  = FK_DATA;
    if (go) begin
      if (brk_req | brk_pend) begin
        start = 1'b1;
        kind  = FK_BREAK;
      end else if (pre_pend) begin
        start = 1'b1;
        kind  = FK_IDLE;
      end else if (hold_full) begin
        start = 1'b1;
        kind  = FK_DATA;
      end
    end
  end

  assign take = start & (kind == FK_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      brk_q    <= 1'b0;
      brk_pend <= 1'b0;
      pre_pend <= 1'b0;
      arm      <= '0;
      tc       <= 1'b1;
    end else begin
      en_q  <= tx_en;
      brk_q <= brk_req;
      if (en_rise)                arm <= ARM_LOAD;
      else if (tick && arm != '0) arm <= arm - 1'b1;
      if (start && kind == FK_BREAK) brk_pend <= 1'b0;
      else if (brk_rise)             brk_pend <= 1'b1;
      if (start && kind == FK_IDLE)  pre_pend <= 1'b0;
      else if (en_rise)              pre_pend <= 1'b1;
      if (acc)                                      tc <= 1'b0;
      else if (tick && last && !start && !hold_full) tc <= 1'b1;
    end
  end
endmodule

// File: rtl/utx_shift.sv
module utx_shift
  import uart_tx_brk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  frame_kind_e   kind,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic          last,
  output logic          txd
);
  localparam int SR_W = DW + 3;
  localparam int CW   = $clog2(SR_W);
  localparam logic [CW-1:0] END_STD = CW'(DW + 1);
  localparam logic [CW-1:0] END_BRK = CW'(DW + 2);

  logic [SR_W-1:0] sr;
  logic [CW-1:0]   cnt, end_at;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sr     <= '1;
      cnt    <= '0;
      end_at <= '0;
    end else if (tick) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        case (kind)
          FK_DATA: begin
            sr     <= {2'b11, data, 1'b0};
            end_at <= END_STD;
          end
          FK_IDLE: begin
            sr     <= '1;
            end_at <= END_STD;
          end
          default: begin
            sr     <= {1'b1, {(SR_W-1){1'b0}}};
            end_at <= END_BRK;
          end
        endcase
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy) begin
        sr  <= {1'b1, sr[SR_W-1:1]};
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign last = busy && (cnt == end_at);
  assign txd  = ~busy | sr[0];
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
  import uart_tx_brk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          tx_en,
  input  logic          brk_req,
  input  logic          ie_empty,
  input  logic          ie_done,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          txd,
  output logic          irq
);
  logic          hold_full, acc, take, start, sh_busy, sh_last, tc_flag;
  logic [DW-1:0] hold_data;
  frame_kind_e   kind;

  assign in_ready = ~hold_full;
  assign acc      = in_valid & in_ready;
  assign irq      = (ie_empty & ~hold_full) | (ie_done & tc_flag);

  utx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr(acc), .wr_data(in_data), .take(take),
    .full(hold_full), .data(hold_data)
  );

  utx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .tx_en(tx_en), .brk_req(brk_req),
    .hold_full(hold_full), .acc(acc), .busy(sh_busy), .last(sh_last),
    .start(start), .kind(kind), .take(take), .tc(tc_flag)
  );

  utx_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .start(start), .kind(kind),
    .data(hold_data), .busy(sh_busy), .last(sh_last), .txd(txd)
  );
endmodule

// File: rtl/uart_tx_brk_chk.sv
module uart_tx_brk_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic tx_en,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic busy,
  input logic tc
);
  // R2: an accepted byte fills the holding register
  p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  // R3: the line only moves after a bit tick
  p_line_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd));

  // R3: a frame starts only on a tick
  p_start_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bit_tick));

  // R4: empty persists without a write
  p_empty_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !in_valid |=> in_ready);

  // R5: an accepted byte clears transmission complete
  p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !tc);

  // R9: nothing starts while disabled
  p_no_start_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en && !busy |=> !busy);

  // R10: no start on the tick coinciding with an enable edge
  p_no_start_at_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) && !busy |=> !busy);
endmodule

bind uart_tx_brk uart_tx_brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
  .in_valid(in_valid), .in_ready(in_ready), .txd(txd),
  .busy(sh_busy), .tc(tc_flag)
);

// File: tb/test_uart_tx_brk.sv
`timescale 1ns/1ps
module test_uart_tx_brk;
  localparam int TP = 4;
  localparam int WD = 100000;

  logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0, tx_en = 1'b0, brk_req = 1'b0;
  logic ie_empty = 1'b0, ie_done = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, txd, irq;

  int checks = 0, fails = 0, cyc = 0, tcnt = 0, run = 0, maxrun = 0;
  string ph = "R1";

  always #2 clk = ~clk;

  uart_tx_brk i_uart_tx_brk (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en), .brk_req(brk_req),
    .ie_empty(ie_empty), .ie_done(ie_done), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .txd(txd), .irq(irq)
  );

  // behavioural reference: line is a queue of pending bit values
  bit mq[$];
  bit m_full, m_tc, m_bp, m_pp, m_enq, m_brkq;
  bit [7:0] m_data;
  int m_arm;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_full = 0; m_tc = 1; m_bp = 0; m_pp = 0; m_enq = 0; m_brkq = 0; m_arm = 0; m_data = 0;
    end else begin
      automatic bit acc = in_valid && !m_full;
      automatic bit re = tx_en && !m_enq;
      automatic bit rb = brk_req && !m_brkq;
      automatic bit full_old = m_full;
      automatic int k = -1;
      automatic bit ending = 0;
      if (bit_tick) begin
        if (mq.size() > 1) mq.delete(0);
        else begin
          ending = (mq.size() == 1);
          if (ending) mq.delete(0);
          if (tx_en && m_arm <= 1 && !re) begin
            if (brk_req || m_bp) begin
              k = 2; m_bp = 0;
              for (int i = 0; i < 11; i++) mq.push_back(i == 10);
            end else if (m_pp) begin
              k = 1; m_pp = 0;
              for (int i = 0; i < 10; i++) mq.push_back(1'b1);
            end else if (m_full) begin
              k = 0; m_full = 0;
              mq.push_back(1'b0);
              for (int i = 0; i < 8; i++) mq.push_back(m_data[i]);
              mq.push_back(1'b1);
            end
          end
          if (ending && k < 0 && !full_old) m_tc = 1;
        end
      end
      if (rb && k != 2) m_bp = 1;
      if (re) m_pp = 1;
      if (re) m_arm = 2;
      else if (bit_tick && m_arm > 0) m_arm--;
      if (acc) begin m_full = 1; m_data = in_data; m_tc = 0; end
      m_enq = tx_en; m_brkq = brk_req;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // tick generator, per-cycle compare and low-run tracking, all away from the edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(ph, "txd", txd, mq.size() ? int'(mq[0]) : 1);
      chk(ph, "in_ready", in_ready, !m_full);
      chk(ph, "irq", irq, (ie_empty && !m_full) || (ie_done && m_tc));
      if (txd === 1'b0) run++; else run = 0;
      if (run > maxrun) maxrun = run;
      tcnt = (tcnt + 1) % TP;
      bit_tick = (tcnt == TP - 1);
    end
    if (cyc > WD) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic send(input logic [7:0] b);
    while (in_ready !== 1'b1) @(negedge clk);
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle();
    int n = 0;
    while ((mq.size() != 0 || m_full || m_bp || m_pp) && n < 2000) begin
      @(negedge clk); n++;
    end
    repeat (2 * TP) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "txd after reset", txd, 1);
    chk("R1", "in_ready after reset", in_ready, 1);
    chk("R1", "irq after reset", irq, 0);

    ph = "R10"; // first enable: delay then preamble (R6)
    tx_en = 1'b1;
    send(8'hA5);
    ph = "R3";  // back-to-back frames
    send(8'h3C); send(8'h81);
    settle();

    ph = "R4";
    ie_empty = 1'b1; repeat (6) @(negedge clk);
    send(8'h5A); settle();
    ie_empty = 1'b0;

    ph = "R5";
    ie_done = 1'b1; repeat (4) @(negedge clk);
    send(8'hC3); settle();
    chk("R5", "irq on complete", irq, 1);
    ie_done = 1'b0;

    ph = "R6"; // low enable pulse mid-frame
    send(8'h55); send(8'h0F);
    repeat (3 * TP) @(negedge clk);
    tx_en = 1'b0; repeat (2) @(negedge clk); tx_en = 1'b1;
    settle();

    ph = "R7"; // single break from a short pulse
    send(8'h12);
    repeat (2 * TP + 1) @(negedge clk);
    maxrun = 0;
    brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
    settle();
    chk("R7", "longest low run", maxrun, 10 * TP);

    ph = "R8"; // held break
    maxrun = 0;
    brk_req = 1'b1; repeat (40 * TP) @(negedge clk); brk_req = 1'b0;
    settle();
    chk("R8", "longest low run", maxrun, 10 * TP);

    ph = "R11"; // break, preamble and data all pending
    send(8'h99); send(8'h66);
    repeat (TP) @(negedge clk);
    brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
    tx_en = 1'b0; @(negedge clk); tx_en = 1'b1;
    settle();

    ph = "R9"; // disabled: byte accepted, line stays high
    tx_en = 1'b0;
    send(8'h77);
    repeat (20 * TP) @(negedge clk);
    chk("R9", "txd while disabled", txd, 1);
    chk("R9", "in_ready with byte held", in_ready, 0);
    tx_en = 1'b1;
    settle();

    ph = "R2";
    send(8'hE7); send(8'h18);
    settle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule